// File: doc/BRIEF.md
# Reference Select and Lock Status Mux

This block sits in front of a phase/frequency detector. It decides which signal acts as the detector's reference: either a programmable division of the oscillator clock or the horizontal sync input. It also decides which feedback signal the detector sees: either the internal feedback from the PLL divider chain or an external feedback pin. Both choices are delivered to the detector model as single-cycle edge pulses. A configurable polarity chooses between the rising and the falling edge.

The block also drives a shared status pin. Depending on two enable bits, that pin carries a constant low, the PLL lock flag, or the phase-adjust lock flag. When both enables are set, it carries either the polarity-corrected sync or the divided oscillator waveform. A separate function output carries either a regenerated sync from the divider chain or the conditioned sync input.

All logic runs on `clk`, which is the oscillator clock. The configuration is held in two internal registers that are loaded together by a one-cycle write strobe. The sync input and both feedback inputs pass through a two-flop synchronizer before any edge is detected.

Top module: `refsel_lock_mux`

## Requirements
- R1: The divided oscillator has period M = V + 2 cycles, where V is `cfg_div[6:0]`; a V of 0 is treated as 1, so M spans 3 to 129. The waveform is high for floor(M/2) cycles starting at count 0, and any configuration write restarts it at count 0.
- R2: `sync_in`, `extfb_in` and `intfb_in` pass through two synchronizing flops. An input value sampled at edge k takes part in edge detection at edge k+2, and the resulting output pulse is one cycle wide after that edge.
- R3: The reference source follows control bit 3 (swap) and `pden_pin`: (0,0) oscillator, (0,1) sync, (1,0) sync, (1,1) oscillator.
- R4: Control bit 5 sets the reference edge for either source: 0 rising, 1 falling.
- R5: Control bit 4 selects the feedback source: 0 gives the internal feedback (rising edge), 1 gives `extfb_in` with its edge set by control bit 6 (0 rising, 1 falling).
- R6: The status output is registered. Control bit 0 enables the PLL lock flag and bit 1 enables the phase-adjust lock flag. With both bits 0 the pin is 0; with only bit 0 set it shows `pll_locked`; with only bit 1 set it shows `dpa_locked`.
- R7: With both status enables set, `cfg_div[7]` chooses the pin's content: 0 gives the synchronized sync XOR control bit 5; 1 gives the divided oscillator waveform.
- R8: Control bit 7 selects the function output: 0 gives `regen_sync` registered once; 1 gives the synchronized sync.
- R9: Control bit 2 is the detector enable; while it is 0, `ref_pulse` and `fb_pulse` stay low.
- R10: Reset holds all outputs low and loads control 0x05 and divider byte 0x80. After reset, the status pin therefore shows `pll_locked`, and the reference source is the oscillator divided by 3 whenever `pden_pin` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, drives all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | One-cycle strobe loading both configuration bytes |
| cfg_ctrl | input | 8 | Control byte (bit fields per R3 to R9) |
| cfg_div | input | 8 | Bits 6:0 divider value, bit 7 status content select |
| pden_pin | input | 1 | Enable pin taking part in reference selection |
| sync_in | input | 1 | Horizontal sync input, asynchronous |
| extfb_in | input | 1 | External feedback input, asynchronous |
| intfb_in | input | 1 | Internal feedback level from the divider chain |
| regen_sync | input | 1 | Regenerated sync from the divider chain |
| pll_locked | input | 1 | PLL lock flag |
| dpa_locked | input | 1 | Phase-adjust lock flag |
| ref_pulse | output | 1 | One-cycle pulse on the chosen reference edge |
| fb_pulse | output | 1 | One-cycle pulse on the chosen feedback edge |
| stat_out | output | 1 | Shared lock/reference status pin |
| func_out | output | 1 | Re-clocked function output |

## Verification
The scoreboard runs under pseudo-random toggling of the sync, both feedback inputs, the regenerated sync and both lock flags. This runs once for every value of the control byte, with `pden_pin` at both levels, and with divider values that cover the full 0..127 range. Sweeping the swap bit against the pin separates the four reference-source cases. Sweeping the polarity bits separates rising-edge from falling-edge detection, because random levels produce both edges. The four status-enable combinations, with the status content bit flipping, separate lock flags, sync and divided oscillator. Directed runs at divider values 0, 1, 2 and 127 measure the status-pin period and high time, which separates M from M±1 and the zero clamp from a literal modulus of 2.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    // Control byte layout
    typedef struct packed {
        logic func_ext;   // 7: function output from synchronized sync
        logic fb_fall;    // 6: external feedback falling edge
        logic ref_fall;   // 5: reference falling edge
        logic fb_ext;     // 4: external feedback source
        logic src_swap;   // 3: swaps the pin's effect on the reference source
        logic det_en;     // 2: detector enable
        logic stat_dpa;   // 1: phase-adjust lock on status pin
        logic stat_pll;   // 0: PLL lock on status pin
    } ctrl_t;

    localparam logic [7:0] CTRL_RST = 8'h05;

    typedef enum logic [1:0] {
        STAT_OFF  = 2'b00,
        STAT_PLL  = 2'b01,
        STAT_DPA  = 2'b10,
        STAT_BOTH = 2'b11
    } stat_mode_e;

    localparam int LN_SYNC = 0;
    localparam int LN_EXT  = 1;
    localparam int LN_INT  = 2;
    localparam int NLANES  = 3;

    function automatic logic edge_of(input logic cur, input logic prev, input logic fall);
        return fall ? (!cur && prev) : (cur && !prev);
    endfunction

endpackage

// File: rtl/refsel_sync.sv
module refsel_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);
    localparam int DEPTH = STAGES + 1;

    logic [WIDTH-1:0] stage_d [DEPTH];
    logic [WIDTH-1:0] stage_q [DEPTH];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q <= stage_d;
        end
    end

    assign cur  = stage_q[STAGES-1];
    assign prev = stage_q[STAGES];

endmodule

// File: rtl/refsel_oscdiv.sv
module refsel_oscdiv #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_val,
    output logic             wave,
    output logic             wave_prev
);
    localparam int CNT_W = DIV_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             wprev;
    } div_st_t;

    div_st_t          st_d, st_q;
    logic [DIV_W-1:0] val_eff;
    logic [CNT_W-1:0] modulus;
    logic [CNT_W-1:0] half;

    always_comb begin
        val_eff  = (div_val == '0) ? DIV_W'(1) : div_val;
        modulus  = {1'b0, val_eff} + CNT_W'(2);
        half     = modulus >> 1;
        wave     = (st_q.cnt < half);
        st_d     = st_q;
        st_d.wprev = wave;
        if (restart || (st_q.cnt == modulus - CNT_W'(1))) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wave_prev = st_q.wprev;

    // R1: count never reaches the modulus
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < modulus);

    // R1: terminal count wraps to zero
    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == modulus - CNT_W'(1)) |=> (st_q.cnt == '0));

    // R1: a configuration write restarts the count
    p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0));

endmodule

// File: rtl/refsel_lock_mux.sv
module refsel_lock_mux #(
    parameter int DIV_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_ctrl,
    input  logic [DIV_W:0]   cfg_div,
    input  logic             pden_pin,
    input  logic             sync_in,
    input  logic             extfb_in,
    input  logic             intfb_in,
    input  logic             regen_sync,
    input  logic             pll_locked,
    input  logic             dpa_locked,
    output logic             ref_pulse,
    output logic             fb_pulse,
    output logic             stat_out,
    output logic             func_out
);
    import refsel_pkg::*;

    localparam logic [DIV_W:0] DIV_RST = {1'b1, {DIV_W{1'b0}}};

    typedef struct packed {
        ctrl_t          ctrl;
        logic [DIV_W:0] div;
        logic           refp;
        logic           fbp;
        logic           stat;
        logic           func;
    } top_st_t;

    top_st_t           st_d, st_q;
    logic [NLANES-1:0] lane_in, syn_cur, syn_prev;
    logic              div_wave, div_wave_prev;
    logic              use_sync, ref_raw, fb_raw;
    stat_mode_e        smode;

    assign lane_in[LN_SYNC] = sync_in;
    assign lane_in[LN_EXT]  = extfb_in;
    assign lane_in[LN_INT]  = intfb_in;

    refsel_sync #(.WIDTH(NLANES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (lane_in),
        .cur  (syn_cur),
        .prev (syn_prev)
    );

    refsel_oscdiv #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (cfg_wr),
        .div_val  (st_q.div[DIV_W-1:0]),
        .wave     (div_wave),
        .wave_prev(div_wave_prev)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.ctrl = ctrl_t'(cfg_ctrl);
            st_d.div  = cfg_div;
        end

        use_sync = st_q.ctrl.src_swap ^ pden_pin;
        ref_raw  = use_sync
                 ? edge_of(syn_cur[LN_SYNC], syn_prev[LN_SYNC], st_q.ctrl.ref_fall)
                 : edge_of(div_wave, div_wave_prev, st_q.ctrl.ref_fall);
        fb_raw   = st_q.ctrl.fb_ext
                 ? edge_of(syn_cur[LN_EXT], syn_prev[LN_EXT], st_q.ctrl.fb_fall)
                 : edge_of(syn_cur[LN_INT], syn_prev[LN_INT], 1'b0);
        st_d.refp = st_q.ctrl.det_en && ref_raw;
        st_d.fbp  = st_q.ctrl.det_en && fb_raw;

        smode = stat_mode_e'({st_q.ctrl.stat_dpa, st_q.ctrl.stat_pll});
        case (smode)
            STAT_OFF:  st_d.stat = 1'b0;
            STAT_PLL:  st_d.stat = pll_locked;
            STAT_DPA:  st_d.stat = dpa_locked;
            default:   st_d.stat = st_q.div[DIV_W] ? div_wave
                                 : (syn_cur[LN_SYNC] ^ st_q.ctrl.ref_fall);
        endcase

        st_d.func = st_q.ctrl.func_ext ? syn_cur[LN_SYNC] : regen_sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ctrl <= ctrl_t'(CTRL_RST);
            st_q.div  <= DIV_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_pulse = st_q.refp;
    assign fb_pulse  = st_q.fbp;
    assign stat_out  = st_q.stat;
    assign func_out  = st_q.func;

    // R9: detector disabled keeps both pulses low
    p_det_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctrl.det_en |=> (!ref_pulse && !fb_pulse));

    // R6: both enables clear drives zero
    p_stat_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.stat_pll && !st_q.ctrl.stat_dpa) |=> !stat_out);

    // R6: PLL lock only
    p_stat_pll_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.stat_pll && !st_q.ctrl.stat_dpa) |=> (stat_out == $past(pll_locked)));

    // R6: phase-adjust lock only
    p_stat_dpa_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.stat_pll && st_q.ctrl.stat_dpa) |=> (stat_out == $past(dpa_locked)));

    // R8: function output follows the synchronized sync
    p_func_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.func_ext |=> (func_out == $past(syn_cur[LN_SYNC])));

endmodule

// File: tb/tb_refsel_lock_mux.sv
module tb_refsel_lock_mux;

    localparam int DIV_W = 7;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           rst_n;
    logic           cfg_wr;
    logic [7:0]     cfg_ctrl;
    logic [DIV_W:0] cfg_div;
    logic           pden_pin, sync_in, extfb_in, intfb_in, regen_sync;
    logic           pll_locked, dpa_locked;
    logic           ref_pulse, fb_pulse, stat_out, func_out;

    refsel_lock_mux #(.DIV_W(DIV_W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ctrl(cfg_ctrl),
        .cfg_div(cfg_div), .pden_pin(pden_pin), .sync_in(sync_in),
        .extfb_in(extfb_in), .intfb_in(intfb_in), .regen_sync(regen_sync),
        .pll_locked(pll_locked), .dpa_locked(dpa_locked),
        .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
        .stat_out(stat_out), .func_out(func_out)
    );

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic r;
        logic f;
        logic s;
        logic fn;
    } exp_t;

    exp_t exp_q [$];
    exp_t got_e;

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_int(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int m_mod(input int v);
        return ((v == 0) ? 1 : v) + 2;
    endfunction

    function automatic logic m_edge(input logic cur, input logic prev, input logic fall);
        if (fall) return !cur && prev;
        return cur && !prev;
    endfunction

    // Scoreboard model: history of input samples, expected outputs per edge
    logic [7:0]     m_ctrl;
    logic [DIV_W:0] m_div;
    logic [2:0]     hs, he, hi;
    int             mcnt;
    logic           wprev;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl <= 8'h05;
            m_div  <= {1'b1, {DIV_W{1'b0}}};
            hs <= '0; he <= '0; hi <= '0;
            mcnt  <= 0;
            wprev <= 1'b0;
        end else begin
            exp_t e;
            logic w, use_sync;
            int   md;
            md = m_mod(int'(m_div[DIV_W-1:0]));
            w  = (mcnt < md / 2);
            use_sync = m_ctrl[3] ^ pden_pin;
            e.r = m_ctrl[2] && (use_sync ? m_edge(hs[1], hs[2], m_ctrl[5])
                                         : m_edge(w, wprev, m_ctrl[5]));
            e.f = m_ctrl[2] && (m_ctrl[4] ? m_edge(he[1], he[2], m_ctrl[6])
                                          : (hi[1] && !hi[2]));
            case (m_ctrl[1:0])
                2'b00: e.s = 1'b0;
                2'b01: e.s = pll_locked;
                2'b10: e.s = dpa_locked;
                default: e.s = m_div[DIV_W] ? w : (hs[1] ^ m_ctrl[5]);
            endcase
            e.fn = m_ctrl[7] ? hs[1] : regen_sync;
            exp_q.push_back(e);
            wprev <= w;
            mcnt  <= cfg_wr ? 0 : ((mcnt == md - 1) ? 0 : mcnt + 1);
            hs <= {hs[1:0], sync_in};
            he <= {he[1:0], extfb_in};
            hi <= {hi[1:0], intfb_in};
            if (cfg_wr) begin
                m_ctrl <= cfg_ctrl;
                m_div  <= cfg_div;
            end
        end
    end

    // Monitor: compare each registered result against the queue head
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            got_e = exp_q.pop_front();
            check(ref_pulse, got_e.r, "R2 R3 R4 R9 ref_pulse");
            check(fb_pulse,  got_e.f, "R2 R5 R9 fb_pulse");
            check(stat_out,  got_e.s, "R1 R6 R7 stat_out");
            check(func_out,  got_e.fn, "R8 func_out");
        end
    end

    logic [15:0] lfsr = 16'hACE1;

    task automatic run_random(input int n);
        repeat (n) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sync_in    = lfsr[0];
            extfb_in   = lfsr[3];
            intfb_in   = lfsr[6];
            regen_sync = lfsr[9];
            pll_locked = lfsr[12];
            dpa_locked = lfsr[14];
        end
    endtask

    task automatic write_cfg(input logic [7:0] c, input logic [DIV_W:0] d);
        @(negedge clk);
        cfg_wr   = 1'b1;
        cfg_ctrl = c;
        cfg_div  = d;
        @(negedge clk);
        cfg_wr   = 1'b0;
    endtask

    task automatic div_period(input int v);
        int   mexp, per, high;
        logic prev, rise;
        mexp = m_mod(v);
        write_cfg(8'h03, {1'b1, DIV_W'(v)});
        prev = stat_out;
        do begin
            @(negedge clk);
            rise = !prev && stat_out;
            prev = stat_out;
        end while (!rise);
        per  = 0;
        high = 0;
        do begin
            if (stat_out) high++;
            per++;
            @(negedge clk);
            rise = !prev && stat_out;
            prev = stat_out;
        end while (!rise);
        check_int(per,  mexp,     "R1 divider period");
        check_int(high, mexp / 2, "R1 divider high time");
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_ctrl = '0; cfg_div = '0;
        pden_pin = 1'b0; sync_in = 1'b0; extfb_in = 1'b0; intfb_in = 1'b0;
        regen_sync = 1'b0; pll_locked = 1'b1; dpa_locked = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(ref_pulse, 1'b0, "R10 reset ref_pulse");
            check(fb_pulse,  1'b0, "R10 reset fb_pulse");
            check(stat_out,  1'b0, "R10 reset stat_out");
            check(func_out,  1'b0, "R10 reset func_out");
        end
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(stat_out, 1'b1, "R10 status shows PLL lock after reset");
        run_random(40);

        for (int c = 0; c < 256; c++) begin
            for (int p = 0; p < 2; p++) begin
                logic [DIV_W-1:0] dv;
                logic             insel;
                dv    = DIV_W'((c * 7 + p * 64) % 128);
                insel = c[3] ^ p[0];
                write_cfg(8'(c), {insel, dv});
                pden_pin = p[0];
                run_random(24);
            end
        end

        pden_pin = 1'b0;
        div_period(0);
        div_period(1);
        div_period(2);
        div_period(127);
        run_random(8);
        finish_run();
    end

endmodule